// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block produces the external memory bus cycles of a small 8-bit processor whose low address byte and data byte share one set of lines. The core hands it a request with a kind (opcode fetch, memory read or memory write), a 16-bit address and, for writes, a data byte. The sequencer then steps through bus states T1 to T4, each made of a fixed number of oscillator periods. It drives the dedicated high address lines, the shared low lines with their output enable, an address latch strobe, and active-low read and write strobes.

Each cycle opens with the low address on the shared lines and a one-period latch strobe, so an external latch can hold the address. On reads and fetches the drivers are released so the memory can answer, and the byte is sampled inside T3. On writes the drivers stay on and the write data replaces the address. An opcode fetch adds a quiet fourth state for internal decode. A one-period done pulse marks the end of every cycle, with the captured byte alongside it. New requests are taken only while the sequencer is idle.

Top module: `mux_bus_seq`

## Requirements
- R1: With the default of three oscillator periods per state, a read (kind 1) or write (kind 2) cycle lasts 9 periods (T1 to T3) and a fetch (kind 0) lasts 12 periods (T1 to T4). Kind 3 behaves as a read. `busy` is high for every period of the cycle and for no other period.
- R2: `ale` is high only in the first period of T1. The low address byte is driven on `ad_out` with `ad_oe` high for all three periods of T1.
- R3: `addr_hi` carries the high byte of the accepted address for every period of the cycle.
- R4: On reads and fetches `ad_oe` is low from T2 onward. `rd_n` is low from the first period of T2 through the second period of T3 (cycle periods 3 to 7) and high in every other period.
- R5: `ad_in` is sampled at the end of the second period of T3. The sampled byte appears on `rdata` during the done period.
- R6: On writes, `wr_n` is low from the second period of T1 through the last period of T2 (cycle periods 1 to 5). `ad_oe` stays high for the whole cycle, and `ad_out` carries the write data from T2 onward.
- R7: During the T4 state of a fetch, `rd_n`, `wr_n` and `ale` are inactive and `ad_oe` is low.
- R8: `done` is high for exactly one period, the last period of the cycle.
- R9: A request (`req_valid` high) is accepted only while `busy` is low. A request raised while busy is ignored: it changes neither the address, the kind nor the length of the running cycle.
- R10: Synchronous active-high `rst` returns the block to idle, even in the middle of a cycle. In idle, `ad_oe` and `ale` are low, `rd_n` and `wr_n` are high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe from the core |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Cycle in progress |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared low address / write data |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared lines as read back from the bus |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | End-of-cycle pulse |
| rdata | output | 8 | Fetched opcode or read data |

## Verification
The assertions check on every cycle that the read and write strobes are never active together, that the shared lines are never driven while read is active, that idle keeps the bus quiet, that the latch strobe and done last a single period, and that the high address does not move within a cycle. Only the bench scenarios show the exact placement of each strobe edge within the states, that the byte is sampled at the right period, that write data follows the address, and that cycles have the right length for each kind. They also show that requests made while busy are ignored and that reset aborts a cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [1:0] {
      KIND_FETCH = 2'd0,
      KIND_READ  = 2'd1,
      KIND_WRITE = 2'd2,
      KIND_RSVD  = 2'd3
   } bus_kind_e;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_T4   = 3'd4
   } tstate_e;
endpackage

// File: rtl/mbs_phase.sv
module mbs_phase
   import mbs_pkg::*;
#(
   parameter int SUBS = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start,
   input  logic                      is_fetch,
   output tstate_e                   ts,
   output logic [$clog2(SUBS)-1:0]   sub,
   output logic                      cycle_end
);
   localparam int SUB_W = $clog2(SUBS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

   tstate_e ts_next;
   logic    last_sub;

   assign last_sub = (sub == SUB_LAST);

   always_comb begin
      case (ts)
         TS_T1:   ts_next = TS_T2;
         TS_T2:   ts_next = TS_T3;
         TS_T3:   ts_next = is_fetch ? TS_T4 : TS_IDLE;
         default: ts_next = TS_IDLE;
      endcase
   end

   assign cycle_end = last_sub && ((ts == TS_T3 && !is_fetch) || ts == TS_T4);

   always_ff @(posedge clk) begin
      if (rst) begin
         ts  <= TS_IDLE;
         sub <= '0;
      end else if (ts == TS_IDLE) begin
         sub <= '0;
         if (start) ts <= TS_T1;
      end else if (last_sub) begin
         sub <= '0;
         ts  <= ts_next;
      end else begin
         sub <= sub + 1'b1;
      end
   end

   AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
      sub <= SUB_LAST); // R1
   AST_IDLE_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
      (ts == TS_IDLE) |-> (sub == '0)); // R1
endmodule

// File: rtl/mbs_strobe.sv
module mbs_strobe
   import mbs_pkg::*;
#(
   parameter int SUBS   = 3,
   parameter int DATA_W = 8
) (
   input  tstate_e                  ts,
   input  logic [$clog2(SUBS)-1:0]  sub,
   input  bus_kind_e                kind,
   input  logic [DATA_W-1:0]        addr_lo,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     cycle_end,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     capture,
   output logic                     done
);
   localparam int SUB_W = $clog2(SUBS);
   localparam logic [SUB_W-1:0] SUB_MID    = SUB_W'(SUBS / 2);
   localparam logic [SUB_W-1:0] SUB_SAMPLE = SUB_W'(SUBS - 2);

   logic is_write;
   logic in_t1, in_t2, in_t3;

   assign is_write = (kind == KIND_WRITE);
   assign in_t1    = (ts == TS_T1);
   assign in_t2    = (ts == TS_T2);
   assign in_t3    = (ts == TS_T3);

   always_comb begin
      ale     = in_t1 && (sub == '0);
      ad_oe   = in_t1 || (is_write && (in_t2 || in_t3));
      ad_out  = in_t1 ? addr_lo : (is_write && (in_t2 || in_t3)) ? wdata : '0;
      rd_n    = !(!is_write && (in_t2 || (in_t3 && sub <= SUB_SAMPLE)));
      wr_n    = !(is_write && ((in_t1 && sub >= SUB_MID) || in_t2));
      capture = !is_write && in_t3 && (sub == SUB_SAMPLE);
      done    = cycle_end;
   end
endmodule

// File: rtl/mbs_capture.sv
module mbs_capture #(
   parameter int DATA_W     = 8,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic              done,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] held;

   always_ff @(posedge clk) begin
      if (rst)          held <= '0;
      else if (capture) held <= ad_in;
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         logic unused_done;
         assign unused_done = done;
         assign rdata = held;
      end else begin : g_gate
         assign rdata = done ? held : '0;
      end
   endgenerate
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int SUBS            = 3,
   parameter bit HOLD_RDATA      = 1'b1,
   parameter bit IDLE_ADDR_HOLD  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req_valid,
   input  logic [1:0]                req_kind,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      busy,
   output logic [ADDR_W-DATA_W-1:0]  addr_hi,
   output logic [DATA_W-1:0]         ad_out,
   output logic                      ad_oe,
   input  logic [DATA_W-1:0]         ad_in,
   output logic                      ale,
   output logic                      rd_n,
   output logic                      wr_n,
   output logic                      done,
   output logic [DATA_W-1:0]         rdata
);
   localparam int HI_W  = ADDR_W - DATA_W;
   localparam int SUB_W = $clog2(SUBS);

   initial begin
      if (SUBS < 3)        $error("SUBS must be at least 3");
      if (DATA_W < 1)      $error("DATA_W must be positive");
      if (ADDR_W <= DATA_W) $error("ADDR_W must exceed DATA_W");
   end

   tstate_e             ts;
   logic [SUB_W-1:0]    sub;
   logic                cycle_end;
   logic                accept;
   logic                capture;
   bus_kind_e           kind_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;

   assign busy   = (ts != TS_IDLE);
   assign accept = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q  <= KIND_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         kind_q  <= bus_kind_e'(req_kind);
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   mbs_phase #(.SUBS(SUBS)) u_phase (
      .clk       (clk),
      .rst       (rst),
      .start     (accept),
      .is_fetch  (kind_q == KIND_FETCH),
      .ts        (ts),
      .sub       (sub),
      .cycle_end (cycle_end)
   );

   mbs_strobe #(.SUBS(SUBS), .DATA_W(DATA_W)) u_strobe (
      .ts        (ts),
      .sub       (sub),
      .kind      (kind_q),
      .addr_lo   (addr_q[DATA_W-1:0]),
      .wdata     (wdata_q),
      .cycle_end (cycle_end),
      .ale       (ale),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .ad_oe     (ad_oe),
      .ad_out    (ad_out),
      .capture   (capture),
      .done      (done)
   );

   mbs_capture #(.DATA_W(DATA_W), .HOLD_RDATA(HOLD_RDATA)) u_capture (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .done    (done),
      .ad_in   (ad_in),
      .rdata   (rdata)
   );

   generate
      if (IDLE_ADDR_HOLD) begin : g_hi_hold
         assign addr_hi = addr_q[ADDR_W-1:DATA_W];
      end else begin : g_hi_zero
         assign addr_hi = busy ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
      end
   endgenerate

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n)); // R4
   AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !ad_oe); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (rd_n && wr_n && !ad_oe && !ale && !done)); // R10
   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy)); // R8
   AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(addr_hi)); // R3
   AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (rst)
      ale |-> ad_oe); // R2
endmodule

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
   logic       clk = 1'b0;
   logic       rst;
   logic       req_valid;
   logic [1:0] req_kind;
   logic [15:0] req_addr;
   logic [7:0] req_wdata;
   logic       busy;
   logic [7:0] addr_hi;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic [7:0] ad_in;
   logic       ale, rd_n, wr_n, done;
   logic [7:0] rdata;

   int tests_run = 0;
   int tests_failed = 0;

   always #5 clk = ~clk;

   mux_bus_seq uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
      .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done), .rdata(rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // busy, ale, rd_n, wr_n, ad_oe, done as one 6-bit vector
   function automatic logic [5:0] ctl_now();
      return {busy, ale, rd_n, wr_n, ad_oe, done};
   endfunction

   task automatic check_idle(input string tag);
      check(tag, {26'd0, ctl_now()}, {26'd0, 6'b001100});
   endtask

   // kind 0 fetch, 1 read, 2 write, 3 read; intrude raises a request mid-cycle
   task automatic run_cycle(input logic [1:0] kind, input logic [15:0] addr,
                            input logic [7:0] wd, input logic [7:0] rd_byte,
                            input bit intrude);
      bit wr;
      int n;
      wr = (kind == 2'd2);
      n  = (kind == 2'd0) ? 12 : 9;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
      ad_in = ~rd_byte;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         logic [5:0] exp_ctl;
         logic [7:0] exp_ad;
         exp_ctl[5] = 1'b1;                                  // R1 busy
         exp_ctl[4] = (k == 0);                              // R2 ale
         exp_ctl[3] = !(!wr && k >= 3 && k <= 7);            // R4 rd_n, R7
         exp_ctl[2] = !(wr && k >= 1 && k <= 5);             // R6 wr_n
         exp_ctl[1] = wr ? (k < 9) : (k < 3);                // R2 R4 R6 R7 ad_oe
         exp_ctl[0] = (k == n - 1);                          // R8 done
         exp_ad     = (k < 3) ? addr[7:0] : wd;
         check($sformatf("R1/R2/R4/R6/R7/R8 ctl kind=%0d k=%0d", kind, k),
               {26'd0, ctl_now()}, {26'd0, exp_ctl});
         check($sformatf("R3 addr_hi kind=%0d k=%0d", kind, k),
               {24'd0, addr_hi}, {24'd0, addr[15:8]});
         if (exp_ctl[1])
            check($sformatf("R2/R6 ad_out kind=%0d k=%0d", kind, k),
                  {24'd0, ad_out}, {24'd0, exp_ad});
         if (!wr && k == n - 1)
            check($sformatf("R5 rdata kind=%0d", kind), {24'd0, rdata}, {24'd0, rd_byte});
         if (intrude && k == 4) begin
            req_valid = 1'b1; req_kind = wr ? 2'd0 : 2'd2;
            req_addr = ~addr; req_wdata = ~wd;
         end
         if (intrude && k == 5) req_valid = 1'b0;
         if (k == 7) ad_in = rd_byte;
         if (k == 8) ad_in = 8'h5A ^ rd_byte;
         @(negedge clk);
      end
      check_idle($sformatf("R1/R9 idle after kind=%0d", kind));
   endtask

   task automatic test_reset_mid();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'hBEEF; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_idle("R10 reset mid-cycle");
      rst = 1'b0;
      @(negedge clk);
      check_idle("R10 stays idle after reset release");
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0;
      req_addr = 16'h0; req_wdata = 8'h0; ad_in = 8'h00;
      repeat (3) @(negedge clk);
      check_idle("R10 reset state");
      rst = 1'b0;
      @(negedge clk);
      check_idle("R10 idle after reset");
      run_cycle(2'd0, 16'h12C4, 8'h00, 8'h3E, 1'b0);   // fetch
      run_cycle(2'd1, 16'hA55A, 8'h00, 8'hC7, 1'b0);   // read
      run_cycle(2'd2, 16'h7F01, 8'h9D, 8'h00, 1'b0);   // write
      run_cycle(2'd3, 16'h0080, 8'h00, 8'h81, 1'b0);   // kind 3 as read
      run_cycle(2'd1, 16'h4321, 8'h00, 8'h66, 1'b1);   // R9 ignored while busy
      run_cycle(2'd2, 16'hFFFF, 8'hA0, 8'h00, 1'b1);   // R9 ignored while busy
      test_reset_mid();
      run_cycle(2'd0, 16'h0000, 8'h00, 8'hFF, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule